// File: doc/BRIEF.md
# Watchdog Countdown Timer with Selectable Timebase and Reset Output Style

This block is a watchdog for supervising system software. An 8-bit time register holds a count of timebase units. While the watchdog is enabled, the count falls by one each unit. A unit is one second or one minute, built from a 1 kHz tick input. Each write of the time register reloads the count, and that write is the keep-alive.

If software stops writing and the count runs from one down to zero, the watchdog has expired. It then sets a sticky status flag and drives an active-low reset output. The output is either held low (level style) or low for one of four fixed durations (pulse style). A separate gate bit can mask the output without stopping the timer.

Software reaches the block through a plain register port: address, write data, write strobe and a combinational read-data output. The block carries no streaming data, so it has no valid/ready handshake. All pins are plain control and status. The register offsets and bit positions listed below are the ones software relies on.

Top module: `wdog_timer`

## Requirements
- R1: After reset, every register bit is 0, the count is 0, the reset output is high, and reads of addresses 0xF0, 0xF5 and 0xF6 return 0.
- R2: A write to address 0xF6 loads the count with the write data and restarts the prescaler. A read of 0xF6 returns the live count.
- R3: Control register 0xF5 bit 5 enables the timer and bit 3 selects the unit (0 = seconds, 1 = minutes). While enabled with a nonzero count, the count falls by one after TICKS_PER_SEC ticks in seconds unit, or after TICKS_PER_SEC*SECS_PER_MIN ticks in minutes unit. Only cycles with `tick_1k` high count.
- R4: While bit 5 of 0xF5 is 0, the count and the prescaler hold their values and the reset output is high. Setting bit 5 again resumes counting from the held prescaler position.
- R5: The count stepping from 1 to 0 sets status bit 6 of 0xF5. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. A clear and an expiry on the same edge leave the bit set.
- R6: In level style (0xF5 bit 4 = 0), the reset output goes low on the expiry edge. It stays low until bit 5 is cleared or 0xF6 is written.
- R7: In pulse style (0xF5 bit 4 = 1), the reset output goes low on the expiry edge for 1, 25, 125 or 5000 ticks, chosen by 0xF5 bits 1:0 = 0, 1, 2 or 3.
- R8: Address 0xF0 bit 7 gates the reset output. While it is 0, the output stays high, but expiry and the status flag still occur. A held level shows once the gate is set.
- R9: A count of zero never expires: the status flag and the output stay unchanged.
- R10: A write to 0xF6 on the same edge as the final step wins. The count reloads, and no expiry, status or output follows.
- R11: Writes to other addresses have no effect. Reads of other addresses return 0, and unused bits of 0xF0 and 0xF5 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1k | input | 1 | Millisecond tick, one cycle high per tick |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| wdt_rst_n | output | 1 | Active-low watchdog reset output |

## Verification
Two functions can fall on one edge: the expiry of the count, and a software write. The write can be a keep-alive to 0xF6 or a status clear to 0xF5. The bench holds the tick high and times each write to land on the exact edge where the count steps from 1 to 0. In the keep-alive case, it judges that the count reloads and that neither status nor output moves. In the status-clear case, it judges that the status flag reads back set. Random traffic against a cycle model in the bench also reaches these collisions by chance.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [7:0] A_GATE = 8'hF0;
  localparam logic [7:0] A_CTRL = 8'hF5;
  localparam logic [7:0] A_TIME = 8'hF6;

  localparam int B_GATE  = 7;
  localparam int B_STS   = 6;
  localparam int B_EN    = 5;
  localparam int B_PULSE = 4;
  localparam int B_UNIT  = 3;

  localparam int PULSE_W = 13;

  typedef struct packed {
    logic       en;
    logic       pulse;
    logic       unit;
    logic [1:0] width;
  } ctrl_t;

  function automatic logic [PULSE_W-1:0] pulse_ticks(input logic [1:0] code);
    case (code)
      2'd0:    return PULSE_W'(1);
      2'd1:    return PULSE_W'(25);
      2'd2:    return PULSE_W'(125);
      default: return PULSE_W'(5000);
    endcase
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       we,
  input  logic       expire,
  input  logic [7:0] count,
  output ctrl_t      ctrl,
  output logic       gate,
  output logic       time_wr,
  output logic [7:0] rdata
);

  logic wr_ctrl, wr_gate, status;

  assign wr_ctrl = we && (addr == A_CTRL);
  assign wr_gate = we && (addr == A_GATE);
  assign time_wr = we && (addr == A_TIME);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      gate   <= 1'b0;
      status <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl.en    <= wdata[B_EN];
        ctrl.pulse <= wdata[B_PULSE];
        ctrl.unit  <= wdata[B_UNIT];
        ctrl.width <= wdata[1:0];
      end
      if (wr_gate) gate <= wdata[B_GATE];
      if (expire) status <= 1'b1;
      else if (wr_ctrl && wdata[B_STS]) status <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_GATE: rdata[B_GATE] = gate;
      A_CTRL: begin
        rdata[B_STS]   = status;
        rdata[B_EN]    = ctrl.en;
        rdata[B_PULSE] = ctrl.pulse;
        rdata[B_UNIT]  = ctrl.unit;
        rdata[1:0]     = ctrl.width;
      end
      A_TIME: rdata = count;
      default: rdata = '0;
    endcase
  end

  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status); // R5
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[B_STS] && !expire) |=> !status); // R5

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       unit,
  input  logic       time_wr,
  input  logic [7:0] time_val,
  output logic [7:0] count,
  output logic       expire
);

  localparam int MIN_TICKS = TICKS_PER_SEC * SECS_PER_MIN;
  localparam int PRE_W     = $clog2(MIN_TICKS + 1);

  logic [PRE_W-1:0] pre, lim;
  logic             step, roll;

  assign lim    = unit ? PRE_W'(MIN_TICKS - 1) : PRE_W'(TICKS_PER_SEC - 1);
  assign step   = en && tick && (count != 8'd0) && !time_wr;
  assign roll   = step && (pre >= lim);
  assign expire = roll && (count == 8'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      pre   <= '0;
    end else if (time_wr) begin
      count <= time_val;
      pre   <= '0;
    end else if (step) begin
      if (roll) begin
        pre   <= '0;
        count <= count - 8'd1;
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  AST_NO_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    !time_wr |=> (count <= $past(count))); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !time_wr) |=> ($stable(count) && $stable(pre))); // R4
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 8'd0) |-> !expire); // R9

endmodule

// File: rtl/wdt_outgen.sv
module wdt_outgen
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       pulse_mode,
  input  logic [1:0] width,
  input  logic       gate,
  input  logic       time_wr,
  input  logic       expire,
  output logic       rst_out_n
);

  logic               lvl;
  logic [PULSE_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl  <= 1'b0;
      pcnt <= '0;
    end else if (time_wr || !en) begin
      lvl  <= 1'b0;
      pcnt <= '0;
    end else if (expire) begin
      if (pulse_mode) pcnt <= pulse_ticks(width);
      else            lvl  <= 1'b1;
    end else if (tick && (pcnt != '0)) begin
      pcnt <= pcnt - PULSE_W'(1);
    end
  end

  assign rst_out_n = !(gate && en && (lvl || (pcnt != '0)));

  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !pulse_mode && en && !time_wr) |=> lvl); // R6
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && pulse_mode && en && !time_wr) |=> (pcnt == pulse_ticks($past(width)))); // R7
  AST_RELOAD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> (!lvl && (pcnt == '0))); // R6

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1k,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata,
  output logic       wdt_rst_n
);

  ctrl_t      ctrl;
  logic       gate, time_wr, expire;
  logic [7:0] count;

  wdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .expire(expire), .count(count), .ctrl(ctrl), .gate(gate),
    .time_wr(time_wr), .rdata(reg_rdata)
  );

  wdt_counter #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .SECS_PER_MIN(SECS_PER_MIN)
  ) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick_1k), .en(ctrl.en), .unit(ctrl.unit),
    .time_wr(time_wr), .time_val(reg_wdata), .count(count), .expire(expire)
  );

  wdt_outgen u_out (
    .clk(clk), .rst_n(rst_n), .tick(tick_1k), .en(ctrl.en),
    .pulse_mode(ctrl.pulse), .width(ctrl.width), .gate(gate),
    .time_wr(time_wr), .expire(expire), .rst_out_n(wdt_rst_n)
  );

  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |-> !expire); // R10

endmodule

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 10;
  localparam int SPM = 4;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [7:0] addr = 8'h00, wd = 8'h00;
  wire  [7:0] rdata;
  wire        rstn_o;
  int nchk = 0, nfail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick), .reg_addr(addr),
    .reg_wdata(wd), .reg_we(we), .reg_rdata(rdata), .wdt_rst_n(rstn_o)
  );

  // cycle model built from the requirements
  int m_cnt, m_pre, m_pc, m_lim;
  bit m_en, m_pm, m_unit, m_gate, m_sts, m_lvl;
  bit [1:0] m_w;
  bit tw, cw, gw, mstep, mroll, mexp;

  function automatic int pw(bit [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 25;
      2'd2: return 125;
      default: return 5000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_pc = 0; m_en = 0; m_pm = 0; m_unit = 0;
      m_gate = 0; m_sts = 0; m_lvl = 0; m_w = 0;
    end else begin
      tw = we && addr == 8'hF6;
      cw = we && addr == 8'hF5;
      gw = we && addr == 8'hF0;
      m_lim = m_unit ? TPS*SPM : TPS;
      mstep = m_en && tick && m_cnt != 0 && !tw;
      mroll = mstep && (m_pre >= m_lim - 1);
      mexp = mroll && m_cnt == 1;
      if (tw || !m_en) begin m_lvl = 0; m_pc = 0; end
      else if (mexp) begin if (m_pm) m_pc = pw(m_w); else m_lvl = 1; end
      else if (tick && m_pc != 0) m_pc = m_pc - 1;
      if (tw) begin m_cnt = int'(wd); m_pre = 0; end
      else if (mstep) begin
        if (mroll) begin m_pre = 0; m_cnt = m_cnt - 1; end
        else m_pre = m_pre + 1;
      end
      if (mexp) m_sts = 1;
      else if (cw && wd[6]) m_sts = 0;
      if (cw) begin m_en = wd[5]; m_pm = wd[4]; m_unit = wd[3]; m_w = wd[1:0]; end
      if (gw) m_gate = wd[7];
    end
  end

  function automatic int exp_rstn();
    return (m_gate && m_en && (m_lvl || m_pc != 0)) ? 0 : 1;
  endfunction

  function automatic int exp_rdata();
    case (addr)
      8'hF0: return {24'd0, m_gate, 7'd0};
      8'hF5: return {24'd0, 1'b0, m_sts, m_en, m_pm, m_unit, 1'b0, m_w};
      8'hF6: return m_cnt & 255;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int expv, string what);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(m_pm ? "R7" : "R6", int'(rstn_o), exp_rstn(), "model rst_n");
      chk(addr == 8'hF6 ? "R3" : (addr == 8'hF5 ? "R5" : "R11"),
          int'(rdata), exp_rdata(), "model rdata");
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wd = d; we = 1'b1;
    step(1);
    we = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    addr = 8'hF0; step(1); chk("R1", int'(rdata), 0, "gate reg");
    chk("R1", int'(rstn_o), 1, "rst_n");
    addr = 8'hF5; step(1); chk("R1", int'(rdata), 0, "ctrl reg");
    addr = 8'hF6; step(1); chk("R1", int'(rdata), 0, "count");
    tick = 1'b1;
    wr(8'hF0, 8'h80);
    wr(8'hF5, 8'h20);
    wr(8'hF6, 8'd3);
    chk("R2", int'(rdata), 3, "count after load");
    step(29); chk("R3", int'(rstn_o), 1, "before expiry"); chk("R3", int'(rdata), 1, "count");
    step(1);  chk("R6", int'(rstn_o), 0, "level at expiry"); chk("R3", int'(rdata), 0, "count");
    addr = 8'hF5; step(1); chk("R5", int'(rdata[6]), 1, "status set");
    step(40); chk("R6", int'(rstn_o), 0, "level held");
    wr(8'hF5, 8'h60); chk("R5", int'(rdata), 8'h20, "status cleared");
    chk("R6", int'(rstn_o), 0, "level held after ctrl write");
    wr(8'hF6, 8'd2); chk("R6", int'(rstn_o), 1, "released by reload");
    // R7 pulse code 1 = 25 ticks
    wr(8'hF5, 8'h31);
    wr(8'hF6, 8'd2);
    step(19); chk("R7", int'(rstn_o), 1, "before pulse");
    step(1);  chk("R7", int'(rstn_o), 0, "pulse start");
    step(24); chk("R7", int'(rstn_o), 0, "pulse last tick");
    step(1);  chk("R7", int'(rstn_o), 1, "pulse end");
    // R3 minutes unit
    wr(8'hF5, 8'h28);
    wr(8'hF6, 8'd1);
    step(39); chk("R3", int'(rstn_o), 1, "minute before");
    step(1);  chk("R3", int'(rstn_o), 0, "minute expiry");
    // R4 freeze
    wr(8'hF5, 8'h20);
    wr(8'hF6, 8'd5);
    step(15); chk("R3", int'(rdata), 4, "seconds step");
    wr(8'hF5, 8'h00);
    addr = 8'hF6;
    step(50); chk("R4", int'(rdata), 4, "frozen count"); chk("R4", int'(rstn_o), 1, "rst_n idle");
    wr(8'hF5, 8'h20);
    addr = 8'hF6;
    step(3); chk("R4", int'(rdata), 4, "resume held prescaler");
    step(1); chk("R4", int'(rdata), 3, "resume step");
    // R8 gate
    wr(8'hF5, 8'h60);
    wr(8'hF0, 8'h00);
    wr(8'hF6, 8'd1);
    step(10); chk("R8", int'(rstn_o), 1, "gated off");
    wr(8'hF0, 8'h80); chk("R8", int'(rstn_o), 0, "gate shows level");
    addr = 8'hF5; step(1); chk("R8", int'(rdata[6]), 1, "status while gated");
    wr(8'hF5, 8'h60);
    // R9 zero reload
    wr(8'hF6, 8'd0);
    step(100); chk("R9", int'(rstn_o), 1, "no output"); chk("R9", int'(rdata), 0, "count");
    addr = 8'hF5; step(1); chk("R9", int'(rdata), 8'h20, "no status");
    // R10 keep-alive on the final step
    wr(8'hF6, 8'd1);
    step(9);
    wr(8'hF6, 8'd5);
    chk("R10", int'(rdata), 5, "reload won"); chk("R10", int'(rstn_o), 1, "no output");
    addr = 8'hF5; step(1); chk("R10", int'(rdata), 8'h20, "no status");
    // R5 clear collides with expiry
    wr(8'hF6, 8'd1);
    step(9);
    wr(8'hF5, 8'h60);
    chk("R5", int'(rdata), 8'h60, "set wins over clear");
    // R11 other addresses and unused bits
    wr(8'h10, 8'hFF);
    addr = 8'h10; step(1); chk("R11", int'(rdata), 0, "other addr read");
    addr = 8'hF5; step(1); chk("R11", int'(rdata), 8'h60, "ctrl untouched");
    wr(8'hF5, 8'hAC); chk("R11", int'(rdata), 8'h68, "unused ctrl bits");
    wr(8'hF0, 8'hFF); chk("R11", int'(rdata), 8'h80, "unused gate bits");
    // random phase against the model
    for (int k = 0; k < 30000; k++) begin
      int r;
      r = int'($urandom % 100);
      tick = ($urandom % 10) < 7;
      if (r < 3) begin
        addr = 8'hF6; wd = 8'($urandom % 8); we = 1'b1;
      end else if (r < 5) begin
        addr = 8'hF5; wd = 8'($urandom) | 8'h20; we = 1'b1;
      end else if (r < 6) begin
        addr = 8'hF5; wd = 8'($urandom); we = 1'b1;
      end else if (r < 7) begin
        addr = 8'hF0; wd = 8'($urandom); we = 1'b1;
      end else if (r < 8) begin
        addr = 8'($urandom); wd = 8'($urandom); we = 1'b1;
      end else begin
        case ($urandom % 4)
          0: addr = 8'hF0;
          1: addr = 8'hF5;
          2: addr = 8'hF6;
          default: addr = 8'h42;
        endcase
        we = 1'b0;
      end
      step(1);
      we = 1'b0;
    end
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule